// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a two-port memory and watches the select of each port: an active-low enable and an address. When both ports are enabled on the same address, it grants the location to one of them. The other port sees an active-low busy, and any write it attempts is suppressed at the gated write-enable output. The memory array itself is not part of the block. The block takes each port's write strobe and hands the array a gated write enable in its place.

A strap input selects the mode. In master mode the block arbitrates and drives the two busy outputs. The winner is the port whose select was already steady on the previous clock edge. When both selects arrive in the same cycle, the left port wins. The decision is registered and held for as long as the collision lasts. In slave mode the block does not arbitrate. Its busy outputs stay high, and the two busy inputs act purely as external write inhibits, so several devices can share the decision of one master. A blocked write is never stored or replayed: the requester must present it again.

Top module: `dpba_top`

## Requirements
- R1: Arbitration depends only on the enables and the addresses. The level of either write strobe never changes which port gets busy.
- R2: In master mode, if either enable is high or the two addresses differ, both `l_busy_no` and `r_busy_no` are 1.
- R3: In master mode, if one port's enable and address were unchanged since the previous rising edge and the other port newly selects the same address, the steady port wins. The newcomer's busy is 0 in that same cycle.
- R4: `l_busy_no` and `r_busy_no` are never both 0.
- R5: In master mode, a port whose busy output is 0 has its gated write (`*_wr_o`) forced to 0. The winning port's write passes unchanged.
- R6: In slave mode (`master_i` = 0), both busy outputs are 1. A 0 on `l_busy_ni` or `r_busy_ni` forces that port's gated write to 0. A 1 lets the port's write through, even while the two ports collide.
- R7: In master mode the busy inputs have no effect: a write passes while both busy inputs are 0.
- R8: If both ports newly select the same address in the same cycle, the left port wins and `r_busy_no` is 0.
- R9: The winner is registered and kept while the match persists. This holds even if both ports then move together to a new common address, which as a fresh tie would favour the left port.
- R10: A blocked write is not replayed. After busy is released, `*_wr_o` is 1 only in cycles where `*_wr_i` is 1.
- R11: A gated write is 1 only while that port's enable is 0 (active). A strobe on a deselected port produces no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | Mode strap: 1 = master (arbitrate, drive busy), 0 = slave (busy inputs inhibit writes) |
| l_en_ni | input | 1 | Left port enable, active low |
| l_addr_i | input | ADDR_W (15) | Left port address |
| l_wr_i | input | 1 | Left port write strobe, active high |
| l_busy_ni | input | 1 | Left external busy, active low (slave mode only) |
| r_en_ni | input | 1 | Right port enable, active low |
| r_addr_i | input | ADDR_W (15) | Right port address |
| r_wr_i | input | 1 | Right port write strobe, active high |
| r_busy_ni | input | 1 | Right external busy, active low (slave mode only) |
| l_busy_no | output | 1 | Left busy, active low (driven in master mode, held 1 in slave mode) |
| r_busy_no | output | 1 | Right busy, active low (driven in master mode, held 1 in slave mode) |
| l_wr_o | output | 1 | Left gated write enable to the array |
| r_wr_o | output | 1 | Right gated write enable to the array |

## Verification
Busy and the gated writes are combinational on the current selects and strobes. The only state is the per-port record of the previous select and the held winner, and both update on the rising edge. A result therefore depends on inputs of the same cycle plus history that ends at the last edge. The bench drives every stimulus on the falling edge and samples 1 ns later, so each check sees the cycle's own inputs against state committed at the preceding rising edge. Ordered scenarios place the first port's select one full edge before the second port's. A reduced 3-bit address lets the sweep cover every address pair under each arrival order and strobe combination.

// File: rtl/dpba_pkg.sv
package dpba_pkg;
  localparam int NPORTS = 2;
  localparam int LEFT   = 0;
  localparam int RIGHT  = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpba_port_track.sv
module dpba_port_track #(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              active_o,
  output logic              fresh_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] addr_q;
  logic              live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      addr_q <= '0;
      live_q <= 1'b0;
    end else begin
      seen_q <= ~en_ni;
      addr_q <= addr_i;
      live_q <= 1'b1;
    end
  end

  assign active_o = ~en_ni;
  // select is new if it was idle last edge or moved to another location
  assign fresh_o  = active_o & (~seen_q | (addr_q != addr_i));

  assert_steady_not_fresh_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !en_ni && !$past(en_ni) && addr_i == $past(addr_i)) |-> !fresh_o);
endmodule

// File: rtl/dpba_arb_core.sv
module dpba_arb_core
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_act_i,
  input  logic              r_act_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              l_fresh_i,
  input  logic              r_fresh_i,
  output logic              match_o,
  output logic              l_lose_o,
  output logic              r_lose_o
);
  owner_e owner_q, owner_d;
  logic   right_new_win;

  assign match_o       = l_act_i & r_act_i & (l_addr_i == r_addr_i);
  // right wins a fresh decision only when it was steady and left is new
  assign right_new_win = l_fresh_i & ~r_fresh_i;

  always_comb begin
    owner_d = owner_q;
    if (!match_o)                owner_d = OWN_NONE;
    else if (owner_q == OWN_NONE) owner_d = right_new_win ? OWN_RIGHT : OWN_LEFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign l_lose_o = match_o & (owner_d == OWN_RIGHT);
  assign r_lose_o = match_o & (owner_d == OWN_LEFT);

  assert_one_loser_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_lose_o && r_lose_o));
  assert_owner_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && owner_q != OWN_NONE) |=> (!match_o || owner_q == $past(owner_q)));
endmodule

// File: rtl/dpba_wr_gate.sv
module dpba_wr_gate (
  input  logic wr_i,
  input  logic active_i,
  input  logic inhibit_i,
  output logic wr_o
);
  assign wr_o = wr_i & active_i & ~inhibit_i;
endmodule

// File: rtl/dpba_top.sv
module dpba_top
  import dpba_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_en_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wr_i,
  input  logic              l_busy_ni,
  input  logic              r_en_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wr_i,
  input  logic              r_busy_ni,
  output logic              l_busy_no,
  output logic              r_busy_no,
  output logic              l_wr_o,
  output logic              r_wr_o
);
  logic [NPORTS-1:0]             en_n, act, fresh, lose, inhibit, wr_in, wr_out, ext_busy_n;
  logic [NPORTS-1:0][ADDR_W-1:0] addr;
  logic                          match;
  logic                          live_q;

  assign en_n       = {r_en_ni, l_en_ni};
  assign addr       = {r_addr_i, l_addr_i};
  assign wr_in      = {r_wr_i, l_wr_i};
  assign ext_busy_n = {r_busy_ni, l_busy_ni};

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    dpba_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_ni   (en_n[p]),
      .addr_i  (addr[p]),
      .active_o(act[p]),
      .fresh_o (fresh[p])
    );

    // master uses its own decision, never the pin level
    assign inhibit[p] = master_i ? lose[p] : ~ext_busy_n[p];

    dpba_wr_gate u_gate (
      .wr_i     (wr_in[p]),
      .active_i (act[p]),
      .inhibit_i(inhibit[p]),
      .wr_o     (wr_out[p])
    );
  end

  dpba_arb_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .l_act_i  (act[LEFT]),
    .r_act_i  (act[RIGHT]),
    .l_addr_i (addr[LEFT]),
    .r_addr_i (addr[RIGHT]),
    .l_fresh_i(fresh[LEFT]),
    .r_fresh_i(fresh[RIGHT]),
    .match_o  (match),
    .l_lose_o (lose[LEFT]),
    .r_lose_o (lose[RIGHT])
  );

  assign l_busy_no = ~(master_i & lose[LEFT]);
  assign r_busy_no = ~(master_i & lose[RIGHT]);
  assign l_wr_o    = wr_out[LEFT];
  assign r_wr_o    = wr_out[RIGHT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  assert_idle_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_en_ni || r_en_ni || l_addr_i != r_addr_i) |-> (l_busy_no && r_busy_no));
  assert_never_both_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!l_busy_no && !r_busy_no));
  assert_busy_blocks_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && (!l_busy_no || !r_busy_no)) |-> !((!l_busy_no && l_wr_o) || (!r_busy_no && r_wr_o)));
  assert_slave_inhibit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no && !(!l_busy_ni && l_wr_o) && !(!r_busy_ni && r_wr_o)));
  assert_winner_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && master_i && match && $past(match)) |->
      (l_busy_no == $past(l_busy_no) && r_busy_no == $past(r_busy_no)));
  assert_no_replay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((l_wr_o && !l_wr_i) || (r_wr_o && !r_wr_i)));
  assert_write_needs_enable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((l_wr_o && l_en_ni) || (r_wr_o && r_en_ni)));
endmodule

// File: tb/dpba_top_tb_top.sv
`timescale 1ns/1ps
module dpba_top_tb_top;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1;
  logic l_en_n = 1'b1, r_en_n = 1'b1, l_wr = 1'b0, r_wr = 1'b0;
  logic l_bin = 1'b1, r_bin = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_busy, r_busy, l_wo, r_wo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dpba_top #(.ADDR_W(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master),
    .l_en_ni(l_en_n), .l_addr_i(l_addr), .l_wr_i(l_wr), .l_busy_ni(l_bin),
    .r_en_ni(r_en_n), .r_addr_i(r_addr), .r_wr_i(r_wr), .r_busy_ni(r_bin),
    .l_busy_no(l_busy), .r_busy_no(r_busy), .l_wr_o(l_wo), .r_wr_o(r_wo)
  );

  // compares {l_busy, r_busy, l_wr_o, r_wr_o}
  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {l_busy, r_busy, l_wo, r_wo};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic drive(input logic le, input logic [AW-1:0] la, input logic lw,
                       input logic re, input logic [AW-1:0] ra, input logic rw);
    @(negedge clk);
    l_en_n = le; l_addr = la; l_wr = lw;
    r_en_n = re; r_addr = ra; r_wr = rw;
    #1;
  endtask

  task automatic idle();
    drive(1'b1, '0, 1'b0, 1'b1, '0, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #3;
    check("reset R2", 4'b1100);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // master sweep; busy inputs held low throughout (R7)
    master = 1'b1; l_bin = 1'b0; r_bin = 1'b0;
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int ord = 0; ord < 3; ord++) begin
          for (int w = 0; w < 4; w++) begin
            logic lw, rw, m, llose, rlose;
            lw = w[0]; rw = w[1];
            m = (a == b);
            llose = m && (ord == 1);
            rlose = m && (ord != 1);
            if (ord == 0)      drive(1'b0, AW'(a), 1'b0, 1'b1, '0, 1'b0);
            else if (ord == 1) drive(1'b1, '0, 1'b0, 1'b0, AW'(b), 1'b0);
            else               idle();
            drive(1'b0, AW'(a), lw, 1'b0, AW'(b), rw);
            if (!m)
              check("R2 R7 no-match release", {2'b11, lw, rw});
            else if (ord == 2)
              check("R8 R1 R5 tie to left", {1'b1, 1'b0, lw, 1'b0});
            else
              check("R3 R1 R5 steady port wins", {~llose, ~rlose, lw & ~llose, rw & ~rlose});
            idle();
          end
        end
      end
    end

    // R2 and R11: one side deselected on equal address, strobes on both
    for (int a = 0; a < 8; a++) begin
      drive(1'b0, AW'(a), 1'b1, 1'b1, AW'(a), 1'b1);
      check("R2 R11 right deselected", 4'b1110);
      drive(1'b1, AW'(a), 1'b1, 1'b0, AW'(a), 1'b1);
      check("R2 R11 left deselected", 4'b1101);
      idle();
    end

    // R9: right steady wins, then both jump together to a new common address
    drive(1'b1, '0, 1'b0, 1'b0, 3'd5, 1'b0);
    drive(1'b0, 3'd5, 1'b1, 1'b0, 3'd5, 1'b1);
    check("R3 right steady wins", 4'b0101);
    drive(1'b0, 3'd2, 1'b1, 1'b0, 3'd2, 1'b1);
    check("R9 winner held across move", 4'b0101);
    drive(1'b0, 3'd2, 1'b1, 1'b0, 3'd2, 1'b1);
    check("R9 winner held steady", 4'b0101);

    // R10: release by right deselecting, left does not get a replayed write
    drive(1'b0, 3'd2, 1'b0, 1'b1, 3'd2, 1'b0);
    check("R10 no replay on release", 4'b1100);
    drive(1'b0, 3'd2, 1'b1, 1'b1, 3'd2, 1'b0);
    check("R10 reissued write passes", 4'b1110);
    idle();

    // slave sweep: busy outputs high, busy inputs gate writes, collisions ignored
    master = 1'b0;
    for (int bi = 0; bi < 4; bi++) begin
      for (int ord = 0; ord < 3; ord++) begin
        l_bin = bi[0]; r_bin = bi[1];
        if (ord == 0)      drive(1'b0, 3'd6, 1'b0, 1'b1, '0, 1'b0);
        else if (ord == 1) drive(1'b1, '0, 1'b0, 1'b0, 3'd6, 1'b0);
        else               idle();
        drive(1'b0, 3'd6, 1'b1, 1'b0, 3'd6, 1'b1);
        check("R6 slave inhibit on collision", {2'b11, bi[0], bi[1]});
        drive(1'b0, 3'd1, 1'b1, 1'b0, 3'd4, 1'b1);
        check("R6 slave inhibit no collision", {2'b11, bi[0], bi[1]});
        idle();
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule